// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an asynchronous DRAM alive and brings it up after power-on. Once reset is released it holds the strobes idle for a programmed pause. It then runs a fixed number of refresh cycles back to back, without asking anyone, because no access may happen before it reports ready. Each refresh cycle lowers the column strobe before the row strobe, so the memory uses its internal row counter and the address pins do not matter. The write enable stays high throughout.

After ready rises, a free-running interval timer adds one refresh to a saturating pending count each time it wraps. While the block is idle and work is pending, it raises a request to the access controller. The controller grants the bus only when it is idle or has closed its page. The block then owns the strobes for one full refresh cycle. Refreshes that pile up while the grant is withheld are kept in the count and serviced one grant at a time.

All timing is in clock cycles. With the default values at a 4 ns clock, the timing is as follows. The pause is 200 µs. Refreshes come every 15.6 µs. The column-to-row lead is 8 ns, the row strobe stays low for 60 ns, and precharge lasts 40 ns. That gives a 108 ns cycle.

Top module: `refresh_seq`

## Requirements
- R1: While reset is held, rasN, casN and weN are 1, and ready, refReq and busOwn are 0.
- R2: After reset is released, no strobe moves and busOwn stays 0 until PAUSE_CYC clock edges have passed. The first casN fall is seen after exactly PAUSE_CYC edges.
- R3: After the pause, exactly INIT_REFS refresh cycles run back to back without refReq. Each starts (LEAD_CYC+ROW_CYC+PRE_CYC) cycles after the previous one. ready rises on the edge that ends the last one and then stays high.
- R4: In every refresh cycle, casN falls LEAD_CYC cycles before rasN falls. rasN stays low for ROW_CYC cycles with casN low. casN and rasN rise on the same edge. Both then stay high for at least PRE_CYC cycles before casN falls again.
- R5: weN is 1 at all times.
- R6: refReq stays 0 before ready. After ready, the interval timer adds one pending refresh every INTERVAL_CYC cycles. The first refReq appears INTERVAL_CYC cycles after ready rises. refReq is 1 whenever the block is idle with a nonzero pending count.
- R7: A refresh after ready starts only on a clock edge where refGnt and refReq are both 1, and casN falls on that edge. refGnt has no effect while refReq is 0.
- R8: The pending count saturates at PEND_MAX. After a withheld grant, exactly min(missed intervals, PEND_MAX) refreshes are issued, one per grant. The interval between grants never exceeds INTERVAL_CYC+WORST_ACCESS_CYC when the controller keeps to its bound.
- R9: busOwn is 1 from the edge where casN falls until the end of the precharge of that cycle.
- R10: refReq drops on the edge after it is granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| refGnt | input | 1 | Bus grant from the access controller |
| refReq | output | 1 | Refresh request to the access controller |
| busOwn | output | 1 | Sequencer drives the strobes this cycle |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, held high |
| ready | output | 1 | Initialization finished, accesses allowed |

## Verification
The grant-gap property takes for granted that the access controller returns a grant within WORST_ACCESS_CYC cycles after a refresh falls due. The stimulus keeps to this by setting that bound above the longest hold-off it applies. The longest is the deliberate starvation that drives the pending count into saturation. The strobe properties assume refGnt is only meaningful while refReq is high. The bench also pulses refGnt alone to show that such a grant is ignored.

// File: rtl/refseq_pkg.sv
package refseq_pkg;

  typedef enum logic [2:0] {
    S_PAUSE,
    S_IDLE,
    S_LEAD,
    S_ROW,
    S_PRE
  } seqState_t;

  typedef enum logic [1:0] {
    PH_LEAD,
    PH_ROW,
    PH_PRE
  } phase_t;

  // control -> datapath
  typedef struct packed {
    logic   loadPhase;
    phase_t phaseSel;
    logic   consume;
    logic   cycleEnd;
  } seqStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic pauseDone;
    logic phaseDone;
    logic pendNz;
    logic initDone;
    logic finalInit;
  } seqStatus_t;

endpackage

// File: rtl/refseq_dp.sv
module refseq_dp
  import refseq_pkg::*;
#(
  parameter int PAUSE_CYC    = 50000,
  parameter int INTERVAL_CYC = 3900,
  parameter int INIT_REFS    = 8,
  parameter int LEAD_CYC     = 2,
  parameter int ROW_CYC      = 15,
  parameter int PRE_CYC      = 10,
  parameter int PEND_MAX     = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t ctl,
  output seqStatus_t stat
);

  localparam int PAUSE_W = $clog2(PAUSE_CYC + 1);
  localparam int PH_MAX  = (LEAD_CYC > ROW_CYC) ?
                           ((LEAD_CYC > PRE_CYC) ? LEAD_CYC : PRE_CYC) :
                           ((ROW_CYC > PRE_CYC) ? ROW_CYC : PRE_CYC);
  localparam int PH_W    = $clog2(PH_MAX + 1);
  localparam int INT_W   = $clog2(INTERVAL_CYC + 1);
  localparam int INIT_W  = $clog2(INIT_REFS + 1);
  localparam int PEND_W  = $clog2(PEND_MAX + 1);

  logic [PAUSE_W-1:0] pauseCnt;
  logic [PH_W-1:0]    phaseCnt, phaseLen;
  logic [INT_W-1:0]   intCnt;
  logic [INIT_W-1:0]  initCnt;
  logic [PEND_W-1:0]  pendCnt;
  logic               tick;

  // power-up pause
  always_ff @(posedge clk) begin
    if (!rstN)              pauseCnt <= PAUSE_W'(PAUSE_CYC - 1);
    else if (pauseCnt != 0) pauseCnt <= pauseCnt - 1'b1;
  end

  // per-phase down counter
  always_comb begin
    case (ctl.phaseSel)
      PH_LEAD: phaseLen = PH_W'(LEAD_CYC - 1);
      PH_ROW:  phaseLen = PH_W'(ROW_CYC - 1);
      default: phaseLen = PH_W'(PRE_CYC - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)              phaseCnt <= '0;
    else if (ctl.loadPhase) phaseCnt <= phaseLen;
    else if (phaseCnt != 0) phaseCnt <= phaseCnt - 1'b1;
  end

  // initialization refresh counter
  always_ff @(posedge clk) begin
    if (!rstN)                             initCnt <= '0;
    else if (ctl.cycleEnd && !stat.initDone) initCnt <= initCnt + 1'b1;
  end

  // interval timer, runs once ready
  assign tick = stat.initDone && (intCnt == INT_W'(INTERVAL_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rstN)              intCnt <= '0;
    else if (tick)          intCnt <= '0;
    else if (stat.initDone) intCnt <= intCnt + 1'b1;
  end

  // saturating pending count
  always_ff @(posedge clk) begin
    if (!rstN) pendCnt <= '0;
    else begin
      case ({tick, ctl.consume && stat.pendNz})
        2'b10:   if (pendCnt != PEND_W'(PEND_MAX)) pendCnt <= pendCnt + 1'b1;
        2'b01:   pendCnt <= pendCnt - 1'b1;
        default: pendCnt <= pendCnt;
      endcase
    end
  end

  assign stat.pauseDone = (pauseCnt == 0);
  assign stat.phaseDone = (phaseCnt == 0);
  assign stat.pendNz    = (pendCnt != 0);
  assign stat.initDone  = (initCnt == INIT_W'(INIT_REFS));
  assign stat.finalInit = (initCnt == INIT_W'(INIT_REFS - 1));

endmodule

// File: rtl/refseq_ctl.sv
module refseq_ctl
  import refseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  seqStatus_t stat,
  input  logic       refGnt,
  output seqStrobe_t ctl,
  output logic       refReq,
  output logic       rasN,
  output logic       casN,
  output logic       busOwn
);

  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_PAUSE;
    else       state <= nextState;
  end

  always_comb begin
    nextState    = state;
    ctl          = '0;
    ctl.phaseSel = PH_LEAD;
    case (state)
      S_PAUSE: if (stat.pauseDone) begin
        nextState     = S_LEAD;
        ctl.loadPhase = 1'b1;
      end
      S_IDLE: if (stat.pendNz && refGnt) begin
        nextState     = S_LEAD;
        ctl.loadPhase = 1'b1;
        ctl.consume   = 1'b1;
      end
      S_LEAD: if (stat.phaseDone) begin
        nextState     = S_ROW;
        ctl.loadPhase = 1'b1;
        ctl.phaseSel  = PH_ROW;
      end
      S_ROW: if (stat.phaseDone) begin
        nextState     = S_PRE;
        ctl.loadPhase = 1'b1;
        ctl.phaseSel  = PH_PRE;
      end
      S_PRE: if (stat.phaseDone) begin
        ctl.cycleEnd = 1'b1;
        if (stat.initDone || stat.finalInit) nextState = S_IDLE;
        else begin
          nextState     = S_LEAD;
          ctl.loadPhase = 1'b1;
        end
      end
      default: nextState = S_PAUSE;
    endcase
  end

  assign refReq = (state == S_IDLE) && stat.pendNz;
  assign rasN   = (state != S_ROW);
  assign casN   = !((state == S_LEAD) || (state == S_ROW));
  assign busOwn = (state == S_LEAD) || (state == S_ROW) || (state == S_PRE);

endmodule

// File: rtl/refresh_seq.sv
module refresh_seq
  import refseq_pkg::*;
#(
  parameter int PAUSE_CYC        = 50000,
  parameter int INTERVAL_CYC     = 3900,
  parameter int INIT_REFS        = 8,
  parameter int LEAD_CYC         = 2,
  parameter int ROW_CYC          = 15,
  parameter int PRE_CYC          = 10,
  parameter int PEND_MAX         = 7,
  parameter int WORST_ACCESS_CYC = 64
) (
  input  logic clk,
  input  logic rstN,
  input  logic refGnt,
  output logic refReq,
  output logic busOwn,
  output logic rasN,
  output logic casN,
  output logic weN,
  output logic ready
);

  seqStrobe_t ctl;
  seqStatus_t stat;

  refseq_dp #(
    .PAUSE_CYC(PAUSE_CYC), .INTERVAL_CYC(INTERVAL_CYC), .INIT_REFS(INIT_REFS),
    .LEAD_CYC(LEAD_CYC), .ROW_CYC(ROW_CYC), .PRE_CYC(PRE_CYC), .PEND_MAX(PEND_MAX)
  ) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .stat(stat)
  );

  refseq_ctl i_ctl (
    .clk(clk), .rstN(rstN), .stat(stat), .refGnt(refGnt), .ctl(ctl),
    .refReq(refReq), .rasN(rasN), .casN(casN), .busOwn(busOwn)
  );

  assign weN   = 1'b1;
  assign ready = stat.initDone;

endmodule

// File: rtl/refseq_chk.sv
module refseq_chk #(
  parameter int INTERVAL_CYC     = 3900,
  parameter int WORST_ACCESS_CYC = 64
) (
  input logic clk,
  input logic rstN,
  input logic refGnt,
  input logic refReq,
  input logic busOwn,
  input logic rasN,
  input logic casN,
  input logic ready
);

  localparam int GAP_LIM = INTERVAL_CYC + WORST_ACCESS_CYC;
  localparam int GAP_W   = $clog2(GAP_LIM + 2);

  logic [GAP_W-1:0] gapCnt;

  always_ff @(posedge clk) begin
    if (!rstN)                              gapCnt <= '0;
    else if (!ready || (refReq && refGnt))  gapCnt <= '0;
    else if (gapCnt <= GAP_W'(GAP_LIM))     gapCnt <= gapCnt + 1'b1;
  end

  // R4: column strobe already low on the cycle before the row strobe falls
  p_cas_leads_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> $past(!casN));

  // R4: both strobes rise together
  p_rise_together_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasN) |-> $rose(casN));

  // R2: strobes idle while not owned before ready
  p_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!ready && !busOwn) |-> (rasN && casN));

  // R3: ready never falls
  p_ready_holds_r3: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> ready);

  // R6: no request before ready
  p_no_early_req_r6: assert property (@(posedge clk) disable iff (!rstN)
    !ready |-> !refReq);

  // R7 / R10: a granted request starts the cycle and drops
  p_grant_starts_r10: assert property (@(posedge clk) disable iff (!rstN)
    (refReq && refGnt) |=> (!refReq && !casN && busOwn));

  // R8: refresh grants never spaced wider than interval plus worst access
  p_grant_gap_r8: assert property (@(posedge clk) disable iff (!rstN)
    gapCnt <= GAP_W'(GAP_LIM));

endmodule

bind refresh_seq refseq_chk #(
  .INTERVAL_CYC(INTERVAL_CYC), .WORST_ACCESS_CYC(WORST_ACCESS_CYC)
) i_chk (
  .clk(clk), .rstN(rstN), .refGnt(refGnt), .refReq(refReq),
  .busOwn(busOwn), .rasN(rasN), .casN(casN), .ready(ready)
);

// File: tb/test_refresh_seq.sv
module test_refresh_seq;

  localparam int PAUSE    = 100;
  localparam int INTERVAL = 200;
  localparam int INITN    = 8;
  localparam int LEAD     = 2;
  localparam int ROW      = 15;
  localparam int PRE      = 10;
  localparam int PMAX     = 3;
  localparam int WORST    = 1200;
  localparam int CYCLEN   = LEAD + ROW + PRE;
  localparam int READYCYC = PAUSE + INITN * CYCLEN;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refGnt = 1'b0;
  logic refReq, busOwn, rasN, casN, weN, ready;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  int expQ[$];

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) cyc <= 0;
    else       cyc <= cyc + 1;
  end

  refresh_seq #(
    .PAUSE_CYC(PAUSE), .INTERVAL_CYC(INTERVAL), .INIT_REFS(INITN),
    .LEAD_CYC(LEAD), .ROW_CYC(ROW), .PRE_CYC(PRE), .PEND_MAX(PMAX),
    .WORST_ACCESS_CYC(WORST)
  ) i_refresh_seq (
    .clk(clk), .rstN(rstN), .refGnt(refGnt), .refReq(refReq),
    .busOwn(busOwn), .rasN(rasN), .casN(casN), .weN(weN), .ready(ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // driver: grant after dly cycles, push expected start cycle
  task automatic grantAfter(input int dly);
    while (!refReq) @(negedge clk);
    repeat (dly) @(negedge clk);
    refGnt = 1'b1;
    expQ.push_back(cyc + 1);
    @(negedge clk);
    refGnt = 1'b0;
    chk(refReq == 1'b0, "R10 request drops after grant", int'(refReq), 0);
  endtask

  // monitor
  logic prevRas = 1'b1, prevCas = 1'b1;
  int casFall = 0, rasFall = 0, lastRise = -1000;
  bit weBad = 1'b0;
  int refCount = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (weN !== 1'b1) weBad = 1'b1;
      if (prevCas && !casN) begin
        refCount++;
        casFall = cyc;
        if (expQ.size() == 0) chk(1'b0, "R7 unexpected refresh start", cyc, -1);
        else begin
          automatic int e = expQ.pop_front();
          chk(cyc == e, "R7/R3 refresh start cycle", cyc, e);
        end
        chk(busOwn == 1'b1, "R9 busOwn at column strobe fall", int'(busOwn), 1);
        chk(cyc - lastRise >= PRE, "R4 precharge before next cycle", cyc - lastRise, PRE);
      end
      if (prevRas && !rasN) begin
        rasFall = cyc;
        chk(cyc - casFall == LEAD, "R4 column lead", cyc - casFall, LEAD);
        chk(weN == 1'b1, "R5 write enable at row fall", int'(weN), 1);
      end
      if (!prevRas && rasN) begin
        lastRise = cyc;
        chk(cyc - rasFall == ROW, "R4 row low width", cyc - rasFall, ROW);
        chk(casN && !prevCas, "R4 strobes rise together", int'(casN), 1);
      end
      if (cyc == lastRise + PRE - 1)
        chk(busOwn == 1'b1, "R9 busOwn through precharge", int'(busOwn), 1);
      prevRas = rasN;
      prevCas = casN;
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    finish();
  end

  initial begin
    int grants;
    repeat (3) @(negedge clk);
    chk({rasN, casN, weN, ready, refReq, busOwn} == 6'b111000, "R1 reset state",
        int'({rasN, casN, weN, ready, refReq, busOwn}), 6'b111000);
    for (int i = 0; i < INITN; i++) expQ.push_back(PAUSE + i * CYCLEN);
    rstN = 1'b1;

    // R2: quiet through the pause
    while (cyc < PAUSE - 1) @(negedge clk);
    chk(rasN && casN && !busOwn, "R2 quiet during pause", int'({rasN, casN, busOwn}), 3'b110);

    // R3: ready timing
    while (cyc < READYCYC - 1) @(negedge clk);
    chk(ready == 1'b0, "R3 ready low before last init cycle ends", int'(ready), 0);
    @(negedge clk);
    chk(ready == 1'b1, "R3 ready rises after init", int'(ready), 1);
    chk(expQ.size() == 0 && refCount == INITN, "R3 init refresh count", refCount, INITN);

    // R6: first two requests on interval boundaries
    while (!refReq) @(negedge clk);
    chk(cyc == READYCYC + INTERVAL, "R6 first request", cyc, READYCYC + INTERVAL);
    grantAfter(0);
    while (!refReq) @(negedge clk);
    chk(cyc == READYCYC + 2 * INTERVAL, "R6 second request", cyc, READYCYC + 2 * INTERVAL);
    grantAfter(0);

    // R8: withhold grants over four intervals, expect saturation
    while (cyc < READYCYC + 6 * INTERVAL + 20) @(negedge clk);
    chk(refReq == 1'b1 && !busOwn, "R8 request held while starved", int'(refReq), 1);
    grants = 0;
    while (cyc < READYCYC + 7 * INTERVAL - 16) begin
      @(negedge clk);
      if (refReq) begin
        grants++;
        grantAfter(0);
      end
    end
    chk(grants == PMAX, "R8 saturated backlog serviced", grants, PMAX);

    // R7: grant without request is ignored
    refGnt = 1'b1;
    repeat (8) @(negedge clk);
    chk(casN && rasN && !busOwn && !refReq, "R7 stray grant ignored",
        int'({casN, rasN, busOwn, refReq}), 4'b1100);
    refGnt = 1'b0;

    // R7: delayed grant
    while (!refReq) @(negedge clk);
    chk(cyc == READYCYC + 7 * INTERVAL, "R6 request after backlog", cyc, READYCYC + 7 * INTERVAL);
    repeat (5) @(negedge clk);
    chk(refReq && casN, "R7 no start before grant", int'({refReq, casN}), 2'b11);
    grantAfter(0);
    repeat (40) @(negedge clk);
    chk(expQ.size() == 0, "R7 all expected refreshes seen", expQ.size(), 0);
    chk(!weBad, "R5 write enable always high", int'(weBad), 0);
    chk(ready == 1'b1, "R3 ready stays high", int'(ready), 1);
    finish();
  end

endmodule